// File: doc/BRIEF.md
# SDRAM Request Splitter and Bank Decoder

This block sits between an application port and a per-bank SDRAM scheduler. It takes one transfer request at a time. A request carries a word address, a length, a read/write flag, a wrap flag and an address mask. The block turns the request into one or more sub-requests. Each sub-request names a bank, a row and a column, and carries its own length, first/final markers and the write flag. A non-wrapping request is cut wherever it would run past the end of the current SDRAM row. A wrap-mode request goes downstream as one fixed four-word piece.

The column width can be 8, 9, 10 or 11 bits. It is chosen at run time and captured when a request is accepted, so the bank and row fields move with it. Each sub-request is presented with a valid/acknowledge handshake and held until the scheduler takes it. The application sees a single-cycle acknowledge once the final piece has been taken. A free indication tells the application when it may present its next request. That indication stays low, and nothing is accepted, until SDRAM initialisation has been reported complete.

Top module: `sdram_req_split`

## Requirements
- R1: The column-width code selects 8, 9, 10 or 11 column bits for codes 0, 1, 2 and 3. `sub_col` is the address modulo 2^bits, zero-extended, and the code is sampled when the request is accepted.
- R2: `sub_bank` is the BANK_W address bits directly above the column bits. `sub_row` is the ROW_W bits directly above the bank bits.
- R3: For a non-wrapping request, each piece length is the smaller of the words still to transfer and the words left in the row (2^bits minus column). Pieces follow one another until the requested length is used up.
- R4: The address of each following piece is (request address AND NOT mask) OR ((previous piece address + previous length) AND mask).
- R5: A wrap-mode request produces exactly one piece of length 4 with both markers set, whatever its column or requested length.
- R6: `sub_start` is 1 only on the first piece of a request, and `sub_last` is 1 only on the final piece.
- R7: While `sub_valid` is 1 and `sub_ack` is 0, `sub_valid` and every sub-request field stay unchanged into the next cycle.
- R8: `app_ack` is high for exactly one cycle: the cycle after the clock edge where the final piece is acknowledged.
- R9: While `init_done` is 0, no request is accepted, `sub_valid` stays 0 and `core_free` stays 0.
- R10: After reset, `sub_valid` and `app_ack` are 0. `core_free` is 1 exactly when the block is idle and `init_done` is 1, and it is 0 while a request is in progress.
- R11: `sub_write` equals the write flag of the request for every one of its pieces.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| init_done | input | 1 | SDRAM initialisation complete |
| cfg_col_sel | input | 2 | Column-width code (8 + code bits) |
| app_req | input | 1 | Application request, held until `app_ack` |
| app_addr | input | ADDR_W | Word address |
| app_mask | input | ADDR_W | Address bits allowed to advance between pieces |
| app_len | input | LEN_W | Request length in words |
| app_wrap | input | 1 | Wrap-mode request (one piece of 4) |
| app_write | input | 1 | 1 = write, 0 = read |
| app_ack | output | 1 | One-cycle pulse when the whole request is issued |
| core_free | output | 1 | Block idle and ready for a request |
| sub_valid | output | 1 | Sub-request present |
| sub_ack | input | 1 | Scheduler takes the present sub-request |
| sub_bank | output | BANK_W | Bank of the piece |
| sub_row | output | ROW_W | Row of the piece |
| sub_col | output | COL_OUT_W | Starting column of the piece |
| sub_len | output | LEN_W | Piece length in words |
| sub_start | output | 1 | First piece of the request |
| sub_last | output | 1 | Final piece of the request |
| sub_write | output | 1 | Write flag of the request |

## Verification
The running address, remaining length and first-piece flag feed the sub-request fields directly. A fault in any of them shows as a wrong bank, row, column or length on the very next piece presented after an acknowledge. A wrong remaining count also shifts where `sub_last` falls, so the number of pieces and the timing of the application acknowledge change by whole handshakes. A control-state fault shows within one cycle as a missing, repeated or stretched `app_ack`, as `core_free` out of step with idleness, or as `sub_valid` raised before initialisation.

// File: rtl/sreq_pkg.sv
package sreq_pkg;
   localparam int MIN_COL_BITS = 8;
   localparam int MAX_COL_BITS = 11;
   localparam int WRAP_LEN     = 4;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_DONE  = 2'd2
   } sreq_state_e;

   // number of column bits for a width code
   function automatic int col_bits(input logic [1:0] sel);
      return MIN_COL_BITS + int'(sel);
   endfunction
endpackage

// File: rtl/sreq_addr_decode.sv
module sreq_addr_decode
   import sreq_pkg::*;
#(
   parameter int ADDR_W    = 25,
   parameter int BANK_W    = 2,
   parameter int ROW_W     = 12,
   parameter int COL_OUT_W = 12
) (
   input  logic [ADDR_W-1:0]    addr,
   input  logic [1:0]           col_sel,
   output logic [COL_OUT_W-1:0] col,
   output logic [BANK_W-1:0]    bank,
   output logic [ROW_W-1:0]     row
);
   logic [ADDR_W-1:0] col_mask;
   logic [ADDR_W-1:0] above;

   always_comb begin
      col_mask = (ADDR_W'(1) << col_bits(col_sel)) - ADDR_W'(1);
      col      = COL_OUT_W'(addr & col_mask);
      above    = addr >> col_bits(col_sel);
   end

   // bank sits right above the column, row right above the bank
   generate
      if (BANK_W == 1) begin : g_two_bank
         assign bank = above[0];
      end else begin : g_multi_bank
         assign bank = above[BANK_W-1:0];
      end
   endgenerate

   assign row = ROW_W'(above >> BANK_W);
endmodule

// File: rtl/sreq_piece_len.sv
module sreq_piece_len
   import sreq_pkg::*;
#(
   parameter int LEN_W     = 9,
   parameter int COL_OUT_W = 12
) (
   input  logic [COL_OUT_W-1:0] col,
   input  logic [1:0]           col_sel,
   input  logic [LEN_W-1:0]     rem,
   input  logic                 wrap,
   output logic [LEN_W-1:0]     plen,
   output logic                 last
);
   localparam int SZ_W = (LEN_W > MAX_COL_BITS + 1) ? LEN_W : MAX_COL_BITS + 1;

   logic [SZ_W-1:0] room;
   logic [SZ_W-1:0] rem_x;

   always_comb begin
      room  = (SZ_W'(1) << col_bits(col_sel)) - SZ_W'(col);
      rem_x = SZ_W'(rem);
      if (wrap) begin
         plen = LEN_W'(WRAP_LEN);
         last = 1'b1;
      end else if (rem_x <= room) begin
         plen = rem;
         last = 1'b1;
      end else begin
         plen = LEN_W'(room);
         last = 1'b0;
      end
   end
endmodule

// File: rtl/sdram_req_split.sv
module sdram_req_split
   import sreq_pkg::*;
#(
   parameter int ROW_W     = 12,
   parameter int NUM_BANKS = 4,
   parameter int LEN_W     = 9,
   parameter int COL_OUT_W = 12,
   localparam int BANK_W   = (NUM_BANKS > 2) ? $clog2(NUM_BANKS) : 1,
   localparam int ADDR_W   = MAX_COL_BITS + BANK_W + ROW_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 init_done,
   input  logic [1:0]           cfg_col_sel,
   input  logic                 app_req,
   input  logic [ADDR_W-1:0]    app_addr,
   input  logic [ADDR_W-1:0]    app_mask,
   input  logic [LEN_W-1:0]     app_len,
   input  logic                 app_wrap,
   input  logic                 app_write,
   output logic                 app_ack,
   output logic                 core_free,
   output logic                 sub_valid,
   input  logic                 sub_ack,
   output logic [BANK_W-1:0]    sub_bank,
   output logic [ROW_W-1:0]     sub_row,
   output logic [COL_OUT_W-1:0] sub_col,
   output logic [LEN_W-1:0]     sub_len,
   output logic                 sub_start,
   output logic                 sub_last,
   output logic                 sub_write
);
   generate
      if (!(NUM_BANKS == 2 || NUM_BANKS == 4)) begin : g_bad_banks
         $error("NUM_BANKS must be 2 or 4");
      end
      if (LEN_W < 3) begin : g_bad_len
         $error("LEN_W must hold the wrap length");
      end
      if (COL_OUT_W < MAX_COL_BITS) begin : g_bad_col
         $error("COL_OUT_W too narrow for the widest column");
      end
   endgenerate

   sreq_state_e       state_q;
   logic [ADDR_W-1:0] base_q, cur_q, mask_q;
   logic [LEN_W-1:0]  rem_q;
   logic [1:0]        csel_q;
   logic              wrap_q, wr_q, first_q;

   logic [LEN_W-1:0]  plen;
   logic              plast;
   logic [ADDR_W-1:0] next_addr;

   sreq_addr_decode #(
      .ADDR_W(ADDR_W), .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_OUT_W(COL_OUT_W)
   ) u_dec (
      .addr(cur_q), .col_sel(csel_q), .col(sub_col), .bank(sub_bank), .row(sub_row)
   );

   sreq_piece_len #(
      .LEN_W(LEN_W), .COL_OUT_W(COL_OUT_W)
   ) u_len (
      .col(sub_col), .col_sel(csel_q), .rem(rem_q), .wrap(wrap_q),
      .plen(plen), .last(plast)
   );

   assign next_addr = (base_q & ~mask_q) | ((cur_q + ADDR_W'(plen)) & mask_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         base_q  <= '0;
         cur_q   <= '0;
         mask_q  <= '0;
         rem_q   <= '0;
         csel_q  <= '0;
         wrap_q  <= 1'b0;
         wr_q    <= 1'b0;
         first_q <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (app_req && init_done) begin
                  state_q <= ST_ISSUE;
                  base_q  <= app_addr;
                  cur_q   <= app_addr;
                  mask_q  <= app_mask;
                  rem_q   <= app_len;
                  csel_q  <= cfg_col_sel;
                  wrap_q  <= app_wrap;
                  wr_q    <= app_write;
                  first_q <= 1'b1;
               end
            end
            ST_ISSUE: begin
               if (sub_ack) begin
                  if (plast) begin
                     state_q <= ST_DONE;
                  end else begin
                     cur_q   <= next_addr;
                     rem_q   <= rem_q - plen;
                     first_q <= 1'b0;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign sub_valid = (state_q == ST_ISSUE);
   assign app_ack   = (state_q == ST_DONE);
   assign core_free = (state_q == ST_IDLE) && init_done;
   assign sub_len   = plen;
   assign sub_last  = plast;
   assign sub_start = first_q;
   assign sub_write = wr_q;

   // R7: an unaccepted piece stays put
   p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sub_valid && !sub_ack |=> sub_valid &&
      $stable({sub_bank, sub_row, sub_col, sub_len, sub_start, sub_last, sub_write}));

   // R8: acknowledge lasts one cycle and follows the final piece
   p_ack_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      app_ack |=> !app_ack);
   p_ack_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(app_ack) |-> $past(sub_valid && sub_ack && sub_last));

   // R9: nothing issued before initialisation
   p_init_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !init_done && !sub_valid |=> !sub_valid);

   // R5: wrap request is one piece of four
   p_wrap_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sub_valid && wrap_q |-> sub_last && sub_start && (sub_len == LEN_W'(WRAP_LEN)));

   // R1: column never wider than the configured width
   p_col_fits_r1: assert property (@(posedge clk) disable iff (!rst_n)
      sub_valid |-> ((sub_col >> col_bits(csel_q)) == '0));

   // R6: after a non-final piece is taken, the next is not marked first
   p_start_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sub_valid && sub_ack && !sub_last |=> sub_valid && !sub_start);
endmodule

// File: tb/sdram_req_split_test.sv
module sdram_req_split_test;
   localparam int ADDR_W = 25;
   localparam int LEN_W  = 9;
   localparam int NV     = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              init_done = 1'b0;
   logic [1:0]        cfg_col_sel = '0;
   logic              app_req = 1'b0;
   logic [ADDR_W-1:0] app_addr = '0;
   logic [ADDR_W-1:0] app_mask = '1;
   logic [LEN_W-1:0]  app_len = '0;
   logic              app_wrap = 1'b0;
   logic              app_write = 1'b0;
   logic              app_ack, core_free, sub_valid;
   logic              sub_ack = 1'b0;
   logic [1:0]        sub_bank;
   logic [11:0]       sub_row;
   logic [11:0]       sub_col;
   logic [LEN_W-1:0]  sub_len;
   logic              sub_start, sub_last, sub_write;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   sdram_req_split uut (
      .clk(clk), .rst_n(rst_n), .init_done(init_done), .cfg_col_sel(cfg_col_sel),
      .app_req(app_req), .app_addr(app_addr), .app_mask(app_mask), .app_len(app_len),
      .app_wrap(app_wrap), .app_write(app_write), .app_ack(app_ack),
      .core_free(core_free), .sub_valid(sub_valid), .sub_ack(sub_ack),
      .sub_bank(sub_bank), .sub_row(sub_row), .sub_col(sub_col), .sub_len(sub_len),
      .sub_start(sub_start), .sub_last(sub_last), .sub_write(sub_write)
   );

   // vectors: address, length, wrap, width code, write, hold cycles, expected pieces
   localparam int T_ADDR[NV] = '{32'h1610, 32'h48DFC, 32'h1579FFE, 32'h1CFF,
                                 32'h1300, 32'hFFFFF0, 32'h480, 32'h5FE};
   localparam int T_LEN [NV] = '{8, 10, 5, 4, 300, 511, 511, 9};
   localparam int T_WRAP[NV] = '{0, 0, 0, 1, 0, 0, 0, 1};
   localparam int T_CS  [NV] = '{0, 0, 3, 0, 1, 2, 0, 1};
   localparam int T_WR  [NV] = '{0, 1, 0, 1, 1, 0, 1, 0};
   localparam int T_HOLD[NV] = '{0, 2, 1, 3, 0, 1, 2, 0};
   localparam int T_NP  [NV] = '{1, 2, 2, 1, 2, 2, 3, 1};

   task automatic chk(input string tag, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic chk_piece(input int cur, input int cs, input int plen, input bit first,
                            input bit last, input bit wr);
      int cw;
      cw = 8 + cs;
      chk("R7 valid", sub_valid, 1);
      chk("R1 column", sub_col, cur & ((1 << cw) - 1));
      chk("R2 bank", sub_bank, (cur >> cw) & 3);
      chk("R2 row", sub_row, (cur >> (cw + 2)) & 12'hFFF);
      chk("R3 length", sub_len, plen);
      chk("R6 start", sub_start, first);
      chk("R6 last", sub_last, last);
      chk("R11 write", sub_write, wr);
   endtask

   task automatic run_req(input int addr, input int len, input bit wrap, input int cs,
                          input bit wr, input int mask, input int hold, input int exp_np);
      int cur, rem, plen, room, cw, np;
      bit first, last;
      while (!core_free) @(negedge clk);
      app_addr    = ADDR_W'(addr);
      app_len     = LEN_W'(len);
      app_wrap    = wrap;
      cfg_col_sel = 2'(cs);
      app_write   = wr;
      app_mask    = ADDR_W'(mask);
      app_req     = 1'b1;
      @(negedge clk);
      chk("R10 busy during request", core_free, 0);
      cur = addr; rem = len; first = 1'b1; np = 0;
      cw  = 8 + cs;
      forever begin
         room = (1 << cw) - (cur & ((1 << cw) - 1));
         if (wrap) begin plen = 4; last = 1'b1; end
         else if (rem <= room) begin plen = rem; last = 1'b1; end
         else begin plen = room; last = 1'b0; end
         chk_piece(cur, cs, plen, first, last, wr);
         if (hold > 0) begin
            repeat (hold) @(negedge clk);
            chk_piece(cur, cs, plen, first, last, wr);   // R7 held
         end
         np++;
         sub_ack = 1'b1;
         @(negedge clk);
         sub_ack = 1'b0;
         if (last) begin
            chk("R8 ack pulse", app_ack, 1);
            chk("R8 no valid after last", sub_valid, 0);
            app_req = 1'b0;
            @(negedge clk);
            chk("R8 ack one cycle", app_ack, 0);
            break;
         end
         chk("R8 no early ack", app_ack, 0);
         cur   = (addr & ~mask) | ((cur + plen) & mask);   // R4
         rem   = rem - plen;
         first = 1'b0;
      end
      chk("R3 piece count", np, exp_np);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R10 reset valid", sub_valid, 0);
      chk("R10 reset ack", app_ack, 0);
      chk("R10 reset free", core_free, 0);
      rst_n = 1'b1;
      // R9: request held before initialisation is not taken
      app_req = 1'b1;
      app_len = 9'd8;
      repeat (5) begin
         @(negedge clk);
         chk("R9 no valid before init", sub_valid, 0);
         chk("R9 not free before init", core_free, 0);
      end
      app_req = 1'b0;
      @(negedge clk);
      init_done = 1'b1;
      @(negedge clk);
      chk("R10 free when idle", core_free, 1);
      chk("R10 no valid when idle", sub_valid, 0);

      for (int i = 0; i < NV; i++) begin
         run_req(T_ADDR[i], T_LEN[i], T_WRAP[i][0], T_CS[i], T_WR[i][0],
                 32'h1FFFFFF, T_HOLD[i], T_NP[i]);
      end

      // R4: mask keeps bank and row while the column advances
      run_req(32'hDF8, 16, 1'b0, 0, 1'b1, 32'hFF, 1, 2);
      // same start, full mask: second piece moves to the next bank
      run_req(32'hDF8, 16, 1'b0, 0, 1'b0, 32'h1FFFFFF, 0, 2);
      // R3: length ending exactly on the row end gives one piece
      run_req(32'h7F0, 16, 1'b0, 1, 1'b0, 32'h1FFFFFF, 0, 1);

      @(negedge clk);
      chk("R10 free after requests", core_free, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule